// File: doc/BRIEF.md
# Command-Port DMA Channel Register File

This block is the programming front end of a multi-channel DMA engine. Software reaches every channel register through only two byte-wide ports. A byte written to the command port names an operation in its high nibble and a channel in its low nibble. Later accesses to the execute port move that operation's operand bytes into or out of the chosen channel, least-significant byte first. An internal byte pointer tracks the position in the operand.

Each channel keeps a 24-bit memory address, a 16-bit count, a 16-bit I/O port number, a mode byte and a mask bit. The count is stored as the transfer length minus one. It is measured in bytes in 8-bit mode and in words in 16-bit mode. The block drives per-channel enable, mode, I/O port and terminal-count outputs. A transfer strobe from the data engine advances the address of the named channel and decrements its count.

Top module: `dmacfg_regfile`

## Requirements
- R1: A command byte holds the operation code in bits 7:4 and the channel number in bits 3:0. A channel number at or above NUM_CH (default 8) leaves every channel unchanged. Execute-port reads under such a command return 0x00.
- R2: Operation 0x0 loads the 16-bit I/O port number from two execute-port writes, low byte then high byte. The value appears on that channel's slice of `chan_ioport`.
- R3: Operation 0x2 loads the 24-bit address from three execute-port writes, in the order bits 7:0, 15:8, 23:16. Operation 0x3 returns the address on three execute-port reads in the same order.
- R4: Operation 0x4 loads the 16-bit count from two writes, low byte first. The value written is the length minus one. Operation 0x5 returns the remaining count, low byte first.
- R5: Operation 0x7 loads the mode byte from one execute-port write, and the channel's slice of `chan_mode` mirrors it. In that byte, bit 0 selects an I/O-register target, bit 2 starts the transfer, bit 3 selects read (clear means write), and bit 6 selects 16-bit units (clear means 8-bit).
- R6: Operation 0x9 masks the named channel and operation 0xA unmasks it, both on the command write itself. `chan_enable` is high only when a channel is unmasked and its mode bit 2 is set.
- R7: A command write clears the byte pointer, and each execute-port access advances it. Writes past the operand length are ignored. A read returns 0x00 past the operand length, and at any point under a non-read operation.
- R8: A new command abandons a partly loaded operand. Bytes already written keep their new values.
- R9: A strobe on an enabled channel adds 1 to the address in 8-bit mode, or 2 in 16-bit mode, modulo 2^24, and subtracts 1 from the count. A strobe on a channel that is not enabled changes nothing.
- R10: A strobe that finds the count at 0 wraps it to 0xFFFF and masks the channel. It also raises that channel's `chan_tc` bit for exactly one cycle.
- R11: Synchronous reset masks every channel and clears address, count, I/O port and mode. All enables and terminal-count bits are low.
- R12: Operation codes other than 0x0, 0x2, 0x3, 0x4, 0x5, 0x7, 0x9 and 0xA are accepted but change no register. Execute accesses under them read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command port |
| exec_wr | input | 1 | Write strobe for the execute port |
| exec_rd | input | 1 | Read strobe for the execute port |
| wdata | input | 8 | Write data for either port |
| rdata | output | 8 | Execute-port read data, valid in the cycle exec_rd is high |
| xfer_strobe | input | 1 | One unit transferred on channel xfer_chan |
| xfer_chan | input | CH_W | Channel that the transfer strobe refers to |
| chan_enable | output | NUM_CH | Per-channel enable (unmasked and started) |
| chan_mode | output | NUM_CH*8 | Per-channel mode byte, channel n at bits 8n+7:8n |
| chan_ioport | output | NUM_CH*16 | Per-channel I/O port, channel n at bits 16n+15:16n |
| chan_tc | output | NUM_CH | Per-channel one-cycle terminal-count pulse |

## Verification
The assertions assume that the command port, the execute port and the transfer strobe are never driven in the same cycle as one another. They also assume that exec_wr and exec_rd are never both high. Under those conditions the relative priority of the sources needs no check. The stimulus drives only one strobe per task and leaves an idle cycle between tasks. It never strobes a channel while that channel is being programmed, and it never unmasks a channel in the cycle that channel reaches terminal count.

// File: rtl/dmacfg_pkg.sv
package dmacfg_pkg;

    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int IOP_W  = 16;

    typedef enum logic [3:0] {
        OP_SET_IOPORT = 4'h0,
        OP_SET_ADDR   = 4'h2,
        OP_GET_ADDR   = 4'h3,
        OP_SET_COUNT  = 4'h4,
        OP_GET_COUNT  = 4'h5,
        OP_SET_MODE   = 4'h7,
        OP_MASK       = 4'h9,
        OP_UNMASK     = 4'hA,
        OP_IDLE       = 4'hF
    } op_e;

    typedef struct packed {
        logic       rsv7;
        logic       wide;      // bit 6: 16-bit units
        logic [1:0] rsv54;
        logic       dir_read;  // bit 3: read transfer
        logic       start;     // bit 2: transfer enabled
        logic       rsv1;
        logic       io_target; // bit 0: I/O register target
    } mode_t;

    function automatic logic [1:0] operand_len(input logic [3:0] op);
        case (op)
            OP_SET_IOPORT: operand_len = 2'd2;
            OP_SET_ADDR:   operand_len = 2'd3;
            OP_GET_ADDR:   operand_len = 2'd3;
            OP_SET_COUNT:  operand_len = 2'd2;
            OP_GET_COUNT:  operand_len = 2'd2;
            OP_SET_MODE:   operand_len = 2'd1;
            default:       operand_len = 2'd0;
        endcase
    endfunction

    function automatic logic is_load_op(input logic [3:0] op);
        is_load_op = (op == OP_SET_IOPORT) || (op == OP_SET_ADDR) ||
                     (op == OP_SET_COUNT)  || (op == OP_SET_MODE);
    endfunction

    function automatic logic is_fetch_op(input logic [3:0] op);
        is_fetch_op = (op == OP_GET_ADDR) || (op == OP_GET_COUNT);
    endfunction

    function automatic logic [23:0] put_byte24(input logic [23:0] v,
                                               input logic [1:0] idx,
                                               input logic [7:0] b);
        logic [23:0] r;
        r = v;
        case (idx)
            2'd0:    r[7:0]   = b;
            2'd1:    r[15:8]  = b;
            2'd2:    r[23:16] = b;
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] put_byte16(input logic [15:0] v,
                                               input logic [1:0] idx,
                                               input logic [7:0] b);
        logic [15:0] r;
        r = v;
        case (idx)
            2'd0:    r[7:0]  = b;
            2'd1:    r[15:8] = b;
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] pick_byte24(input logic [23:0] v,
                                               input logic [1:0] idx);
        case (idx)
            2'd0:    pick_byte24 = v[7:0];
            2'd1:    pick_byte24 = v[15:8];
            2'd2:    pick_byte24 = v[23:16];
            default: pick_byte24 = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/dmacfg_decoder.sv
module dmacfg_decoder
    import dmacfg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              exec_wr,
    input  logic              exec_rd,
    input  logic [7:0]        wdata,
    output logic [3:0]        op_q,
    output logic [1:0]        ptr_q,
    output logic [NUM_CH-1:0] load_vec,
    output logic [NUM_CH-1:0] sel_vec,
    output logic [NUM_CH-1:0] mask_vec,
    output logic [NUM_CH-1:0] unmask_vec,
    output logic              fetch_ok
);
    logic [3:0] chan_q;
    logic       chan_ok;
    logic       in_range;
    logic       load_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            chan_q <= 4'd0;
            ptr_q  <= 2'd0;
        end else if (cmd_wr) begin
            op_q   <= wdata[7:4];
            chan_q <= wdata[3:0];
            ptr_q  <= 2'd0;
        end else if ((exec_wr || exec_rd) && (ptr_q != 2'd3)) begin
            ptr_q  <= ptr_q + 2'd1;
        end
    end

    assign chan_ok  = int'(chan_q) < NUM_CH;
    assign in_range = ptr_q < operand_len(op_q);
    assign load_go  = exec_wr && !cmd_wr && chan_ok && in_range && is_load_op(op_q);
    assign fetch_ok = chan_ok && in_range && is_fetch_op(op_q);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign sel_vec[g]    = chan_ok && (chan_q == 4'(g));
        assign load_vec[g]   = load_go && sel_vec[g];
        assign mask_vec[g]   = cmd_wr && (wdata[7:4] == OP_MASK)   && (wdata[3:0] == 4'(g));
        assign unmask_vec[g] = cmd_wr && (wdata[7:4] == OP_UNMASK) && (wdata[3:0] == 4'(g));
    end

    // R7: the byte pointer restarts after every command write
    assert_ptr_restart_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (ptr_q == 2'd0));

endmodule

// File: rtl/dmacfg_channel.sv
module dmacfg_channel
    import dmacfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [3:0]          op,
    input  logic [1:0]          byte_idx,
    input  logic [7:0]          wdata,
    input  logic                mask_set,
    input  logic                mask_clr,
    input  logic                strobe,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [CNT_W-1:0]    count_q,
    output logic [IOP_W-1:0]    ioport_q,
    output mode_t               mode_q,
    output logic                enabled,
    output logic                tc_q
);
    logic masked_q;
    logic step;
    logic wr_addr, wr_cnt, wr_iop, wr_mode;
    logic [ADDR_W-1:0] addr_inc;

    assign enabled  = !masked_q && mode_q.start;
    assign step     = strobe && enabled;
    assign wr_iop   = load && (op == OP_SET_IOPORT);
    assign wr_addr  = load && (op == OP_SET_ADDR);
    assign wr_cnt   = load && (op == OP_SET_COUNT);
    assign wr_mode  = load && (op == OP_SET_MODE);
    assign addr_inc = mode_q.wide ? ADDR_W'(2) : ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            count_q  <= '0;
            ioport_q <= '0;
            mode_q   <= '0;
            masked_q <= 1'b1;
            tc_q     <= 1'b0;
        end else begin
            tc_q <= step && (count_q == '0);

            if (wr_addr)   addr_q <= put_byte24(addr_q, byte_idx, wdata);
            else if (step) addr_q <= addr_q + addr_inc;

            if (wr_cnt)    count_q <= put_byte16(count_q, byte_idx, wdata);
            else if (step) count_q <= count_q - CNT_W'(1);

            if (wr_iop)  ioport_q <= put_byte16(ioport_q, byte_idx, wdata);
            if (wr_mode) mode_q   <= mode_t'(wdata);

            if (step && (count_q == '0)) masked_q <= 1'b1;
            else if (mask_set)           masked_q <= 1'b1;
            else if (mask_clr)           masked_q <= 1'b0;
        end
    end

    // R10: terminal count leaves the channel masked
    assert_tc_masks_R10: assert property (@(posedge clk) disable iff (rst)
        tc_q |-> (masked_q && !enabled));

    // R10: terminal count lasts one cycle
    assert_tc_single_R10: assert property (@(posedge clk) disable iff (rst)
        tc_q |=> !tc_q);

    // R9: with no strobe and no load, address and count hold
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !load) |=> ($stable(addr_q) && $stable(count_q)));

    // R9: an accepted strobe decrements the count by one
    assert_step_count_R9: assert property (@(posedge clk) disable iff (rst)
        (strobe && enabled && !load) |=> (count_q == $past(count_q) - 16'd1));

endmodule

// File: rtl/dmacfg_regfile.sv
module dmacfg_regfile
    import dmacfg_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  logic                  exec_wr,
    input  logic                  exec_rd,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic                  xfer_strobe,
    input  logic [CH_W-1:0]       xfer_chan,
    output logic [NUM_CH-1:0]     chan_enable,
    output logic [NUM_CH*8-1:0]   chan_mode,
    output logic [NUM_CH*16-1:0]  chan_ioport,
    output logic [NUM_CH-1:0]     chan_tc
);
    logic [3:0]        op_q;
    logic [1:0]        ptr_q;
    logic [NUM_CH-1:0] load_vec, sel_vec, mask_vec, unmask_vec, stb_vec;
    logic              fetch_ok;
    logic [ADDR_W-1:0] addr_arr  [NUM_CH];
    logic [CNT_W-1:0]  count_arr [NUM_CH];
    mode_t             mode_arr  [NUM_CH];
    logic [IOP_W-1:0]  iop_arr   [NUM_CH];

    dmacfg_decoder #(.NUM_CH(NUM_CH)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .exec_wr    (exec_wr),
        .exec_rd    (exec_rd),
        .wdata      (wdata),
        .op_q       (op_q),
        .ptr_q      (ptr_q),
        .load_vec   (load_vec),
        .sel_vec    (sel_vec),
        .mask_vec   (mask_vec),
        .unmask_vec (unmask_vec),
        .fetch_ok   (fetch_ok)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign stb_vec[g] = xfer_strobe && (xfer_chan == CH_W'(g));

        dmacfg_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .load     (load_vec[g]),
            .op       (op_q),
            .byte_idx (ptr_q),
            .wdata    (wdata),
            .mask_set (mask_vec[g]),
            .mask_clr (unmask_vec[g]),
            .strobe   (stb_vec[g]),
            .addr_q   (addr_arr[g]),
            .count_q  (count_arr[g]),
            .ioport_q (iop_arr[g]),
            .mode_q   (mode_arr[g]),
            .enabled  (chan_enable[g]),
            .tc_q     (chan_tc[g])
        );

        assign chan_mode[g*8 +: 8]    = mode_arr[g];
        assign chan_ioport[g*16 +: 16] = iop_arr[g];
    end

    // Read-back: OR of the selected channel's fields (sel_vec is one-hot or zero)
    logic [ADDR_W-1:0] addr_pick;
    logic [CNT_W-1:0]  cnt_pick;
    logic [7:0]        byte_pick;

    always_comb begin
        addr_pick = '0;
        cnt_pick  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_vec[c]) begin
                addr_pick = addr_pick | addr_arr[c];
                cnt_pick  = cnt_pick  | count_arr[c];
            end
        end
        if (op_q == OP_GET_ADDR) byte_pick = pick_byte24(addr_pick, ptr_q);
        else                     byte_pick = pick_byte24({8'h00, cnt_pick}, ptr_q);
        rdata = (exec_rd && fetch_ok) ? byte_pick : 8'h00;
    end

    // R1: at most one channel is the target of the execute port
    assert_single_target_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_vec) && $onehot0(load_vec));

endmodule

// File: tb/dmacfg_regfile_test.sv
module dmacfg_regfile_test;
    localparam int NCH = 8;

    logic clk = 0, rst = 1;
    logic cmd_wr = 0, exec_wr = 0, exec_rd = 0, xfer_strobe = 0;
    logic [7:0] wdata = 0;
    logic [2:0] xfer_chan = 0;
    logic [7:0] rdata;
    logic [NCH-1:0] chan_enable, chan_tc;
    logic [NCH*8-1:0] chan_mode;
    logic [NCH*16-1:0] chan_ioport;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dmacfg_regfile #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .exec_wr(exec_wr),
        .exec_rd(exec_rd), .wdata(wdata), .rdata(rdata),
        .xfer_strobe(xfer_strobe), .xfer_chan(xfer_chan),
        .chan_enable(chan_enable), .chan_mode(chan_mode),
        .chan_ioport(chan_ioport), .chan_tc(chan_tc)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_addr[NCH], m_cnt[NCH], m_iop[NCH], m_mode[NCH];
    bit m_mask[NCH], m_tc[NCH];
    int m_op, m_ch, m_ptr;

    function automatic int oplen(input int op);
        case (op)
            0: return 2; 2: return 3; 3: return 3;
            4: return 2; 5: return 2; 7: return 1;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_addr[c] = 0; m_cnt[c] = 0; m_iop[c] = 0; m_mode[c] = 0;
                m_mask[c] = 1; m_tc[c] = 0;
            end
            m_op = 15; m_ch = 0; m_ptr = 0;
        end else begin
            for (int c = 0; c < NCH; c++) m_tc[c] = 0;
            if (xfer_strobe) begin
                int c;
                c = int'(xfer_chan);
                if (!m_mask[c] && (m_mode[c] & 4) != 0) begin
                    m_addr[c] = (m_addr[c] + (((m_mode[c] & 64) != 0) ? 2 : 1)) & 24'hFFFFFF;
                    if (m_cnt[c] == 0) begin
                        m_cnt[c] = 16'hFFFF; m_mask[c] = 1; m_tc[c] = 1;
                    end else m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (cmd_wr) begin
                m_op = int'(wdata[7:4]); m_ch = int'(wdata[3:0]); m_ptr = 0;
                if (m_ch < NCH && m_op == 9)  m_mask[m_ch] = 1;
                if (m_ch < NCH && m_op == 10) m_mask[m_ch] = 0;
            end else if (exec_wr || exec_rd) begin
                if (exec_wr && m_ch < NCH && m_ptr < oplen(m_op)) begin
                    int sh;
                    sh = 8 * m_ptr;
                    case (m_op)
                        0: m_iop[m_ch]  = (m_iop[m_ch]  & ~(255 << sh)) | (int'(wdata) << sh);
                        2: m_addr[m_ch] = (m_addr[m_ch] & ~(255 << sh)) | (int'(wdata) << sh);
                        4: m_cnt[m_ch]  = (m_cnt[m_ch]  & ~(255 << sh)) | (int'(wdata) << sh);
                        7: m_mode[m_ch] = int'(wdata);
                        default: ;
                    endcase
                end
                if (m_ptr < 3) m_ptr++;
            end
        end
        #5;
        for (int c = 0; c < NCH; c++) begin
            chk("R6 enable vs model", int'(chan_enable[c]),
                int'(!m_mask[c] && (m_mode[c] & 4) != 0));
            chk("R5 mode vs model", int'(chan_mode[c*8 +: 8]), m_mode[c]);
            chk("R2 ioport vs model", int'(chan_ioport[c*16 +: 16]), m_iop[c]);
            chk("R10 tc vs model", int'(chan_tc[c]), int'(m_tc[c]));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cmd(input logic [7:0] b);
        @(negedge clk); cmd_wr = 1; wdata = b;
        @(negedge clk); cmd_wr = 0;
    endtask

    task automatic ewr(input logic [7:0] b);
        @(negedge clk); exec_wr = 1; wdata = b;
        @(negedge clk); exec_wr = 0;
    endtask

    task automatic erd(input int exp, input string tag);
        @(negedge clk); exec_rd = 1;
        #5 chk(tag, int'(rdata), exp);
        @(negedge clk); exec_rd = 0;
    endtask

    task automatic stb(input int c);
        @(negedge clk); xfer_strobe = 1; xfer_chan = 3'(c);
        @(negedge clk); xfer_strobe = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R11 enables after reset", int'(chan_enable), 0);
        chk("R11 tc after reset", int'(chan_tc), 0);
        chk("R11 mode after reset", int'(chan_mode[63:0] != 0), 0);
        cmd(8'h30);
        erd(8'h00, "R11 addr byte0 after reset");
        erd(8'h00, "R11 addr byte1 after reset");

        // R2 I/O port, low byte first
        cmd(8'h01); ewr(8'h34); ewr(8'h12); #1;
        chk("R2 ioport ch1", int'(chan_ioport[31:16]), 16'h1234);

        // R3 address load and read-back, R7 overrun read
        cmd(8'h22); ewr(8'hEF); ewr(8'hCD); ewr(8'hAB);
        cmd(8'h32);
        erd(8'hEF, "R3 addr byte0"); erd(8'hCD, "R3 addr byte1"); erd(8'hAB, "R3 addr byte2");
        erd(8'h00, "R7 read past operand");

        // R4 count = length-1
        cmd(8'h42); ewr(8'h03); ewr(8'h00);
        cmd(8'h52); erd(8'h03, "R4 count low"); erd(8'h00, "R4 count high");

        // R5 mode, R6 unmask
        cmd(8'h72); ewr(8'h04); #1;
        chk("R5 mode ch2", int'(chan_mode[23:16]), 8'h04);
        chk("R6 masked channel not enabled", int'(chan_enable), 0);
        cmd(8'hA2); #1;
        chk("R6 unmask enables ch2", int'(chan_enable), 8'b0000_0100);

        // R9/R10 four units: 3,2,1,0 then wrap
        stb(2); stb(2); stb(2); #1;
        chk("R10 no tc before wrap", int'(chan_tc), 0);
        stb(2); #1;
        chk("R10 tc pulse on wrap", int'(chan_tc), 8'b0000_0100);
        chk("R10 self-mask on wrap", int'(chan_enable), 0);
        stb(2);   // R9 strobe on masked channel is ignored
        cmd(8'h32);
        erd(8'hF3, "R9 addr advanced byte0"); erd(8'hCD, "R9 addr byte1"); erd(8'hAB, "R9 addr byte2");
        cmd(8'h52);
        erd(8'hFF, "R10 count wrapped low"); erd(8'hFF, "R10 count wrapped high");

        // R9 16-bit mode steps by 2
        cmd(8'h23); ewr(8'h10); ewr(8'h00); ewr(8'h00);
        cmd(8'h43); ewr(8'h01); ewr(8'h00);
        cmd(8'h73); ewr(8'h44);
        cmd(8'hA3);
        stb(3);
        cmd(8'h33); erd(8'h12, "R9 wide addr step");
        cmd(8'h53); erd(8'h00, "R9 wide count step");
        #1 chk("R9 still enabled before wrap", int'(chan_enable), 8'b0000_1000);

        // R1 out-of-range channel ignored
        cmd(8'h2C); ewr(8'h55); ewr(8'h66); ewr(8'h77);
        cmd(8'h34); erd(8'h00, "R1 ch12 did not alias ch4"); erd(8'h00, "R1 ch4 byte1");
        cmd(8'h3C); erd(8'h00, "R1 read of ch12");
        cmd(8'hAC); #1;
        chk("R1 unmask ch12 no effect", int'(chan_enable), 8'b0000_1000);

        // R8 abort keeps written bytes
        cmd(8'h25); ewr(8'h11); ewr(8'h22);
        cmd(8'h35);
        erd(8'h11, "R8 byte0 kept"); erd(8'h22, "R8 byte1 kept"); erd(8'h00, "R8 byte2 untouched");

        // R12 unassigned op
        cmd(8'h15); ewr(8'hFF); ewr(8'hFF);
        cmd(8'h35); erd(8'h11, "R12 op1 left addr");
        cmd(8'h65); erd(8'h00, "R12 op6 reads zero");

        // R7 write past operand ignored; read under load op is zero
        cmd(8'h75); ewr(8'h41); ewr(8'h04); #1;
        chk("R7 extra mode byte ignored", int'(chan_mode[47:40]), 8'h41);
        cmd(8'h25); erd(8'h00, "R7 read under load op");

        // R6 mask op
        cmd(8'h93); #1;
        chk("R6 mask disables ch3", int'(chan_enable), 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule